// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of several would-be bus masters may drive a shared data bus. Every device has a request line. The controller sees all of the requests as one combined request. While the bus is idle and at least one device is requesting, the controller sends one grant into a chain of per-device pass cells. The chain starts at the device with the highest priority and runs toward the lowest.

A cell whose device is not requesting passes the grant on to the next cell unchanged. The first requesting cell keeps the grant and stops it from going further. That device then becomes bus master, and a registered bus-busy flag is set.

The master keeps the bus until it pulses its transfer-done line. On the next cycle the bus is idle. On that idle cycle the chain grant is offered again, and every device still requesting competes, the previous master included. The block has outputs for the grant of each device, bus busy, and the binary index of the current master.

Top module: `daisy_arbiter`

## Requirements
- R1: During and directly after reset, bus busy is 0, every grant line is 0 and the master index is 0.
- R2: While idle with no request asserted, the block stays idle: busy 0, no grant.
- R3: When the bus is idle and any request is asserted at a rising edge, busy is 1 after that edge and exactly one grant line is 1.
- R4: Device 0 has the highest priority. When several devices request at the same edge, the requester with the lowest index wins. Grant bit i belongs to device i.
- R5: While busy, the master index output holds the binary number of the granted device. While idle it reads 0.
- R6: The grant and busy hold for as long as the master has not pulsed done. This holds even if the master drops its request.
- R7: A done pulse from a device that is not the master has no effect, and so does any done pulse while the bus is idle.
- R8: A done pulse from the master at an edge clears busy, all grants and the index after that edge. The bus is then idle for at least one cycle.
- R9: A master whose request is still asserted after its done pulse competes again on the idle cycle, and it wins again if it is the lowest-index requester.
- R10: A request raised while the bus is busy does not take the bus from the current master, even if that request has higher priority. It is served only after the master releases the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NDEV | Request line for each device |
| done_i | input | NDEV | Transfer-done strobe for each device |
| grant_o | output | NDEV | Registered grant for each device, one-hot while busy |
| bus_busy_o | output | 1 | Shared bus-busy flag |
| master_o | output | max(1,clog2(NDEV)) | Index of the current master |

## Verification
A request seen at an idle edge shows on busy, grant and index one edge later. A done pulse from the master clears those outputs one edge later. Because of this, the bench drives each stimulus on the falling edge and checks the outputs on the next falling edge, half a cycle after the single register stage has updated.

Arbitration from idle is swept over all fifteen non-empty request patterns of a four-device build. Each pattern's expected winner is taken arithmetically as the lowest set bit of the pattern. The hold, ignore, release and re-compete checks are each made one cycle after their own stimulus.

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
  parameter int NDEV = 8,
  localparam int IW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] req_i,
  input  logic [NDEV-1:0] done_i,
  output logic [NDEV-1:0] grant_o,
  output logic            bus_busy_o,
  output logic [IW-1:0]   master_o
);

  logic            busy_q;
  logic [NDEV-1:0] grant_q;
  logic [IW-1:0]   idx_q;
  logic [NDEV-1:0] pass;
  logic [NDEV-1:0] take;
  logic [IW-1:0]   idx_next;
  logic            release_bus;

  assign pass[0] = (|req_i) & ~busy_q;

  generate
    for (genvar i = 0; i < NDEV; i++) begin : g_cell
      assign take[i] = pass[i] & req_i[i];
      if (i < NDEV - 1) begin : g_fwd
        assign pass[i+1] = pass[i] & ~req_i[i];
      end
    end
  endgenerate

  always_comb begin
    idx_next = '0;
    for (int i = 0; i < NDEV; i++)
      if (take[i]) idx_next = IW'(i);
  end

  assign release_bus = |(done_i & grant_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
      idx_q   <= '0;
    end else if (busy_q && release_bus) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
      idx_q   <= '0;
    end else if (!busy_q && (|take)) begin
      busy_q  <= 1'b1;
      grant_q <= take;
      idx_q   <= idx_next;
    end
  end

  assign grant_o    = grant_q;
  assign bus_busy_o = busy_q;
  assign master_o   = idx_q;

endmodule

// File: rtl/daisy_arbiter_chk.sv
module daisy_arbiter_chk #(
  parameter int NDEV = 8,
  localparam int IW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDEV-1:0] req_i,
  input logic [NDEV-1:0] done_i,
  input logic [NDEV-1:0] grant_o,
  input logic            bus_busy_o,
  input logic [IW-1:0]   master_o
);

  // R3
  claim_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy_o && (|req_i)) |=> bus_busy_o);

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (bus_busy_o == (grant_o != '0)));

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy_o && (|req_i)) |=> (grant_o == ($past(req_i) & (~$past(req_i) + 1'b1))));

  // R5
  index_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy_o |-> grant_o[master_o]);

  // R6
  hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy_o && !(|(done_i & grant_o))) |=> (bus_busy_o && $stable(grant_o)));

  // R8
  release_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy_o && (|(done_i & grant_o))) |=> (!bus_busy_o && grant_o == '0));

endmodule

bind daisy_arbiter daisy_arbiter_chk #(.NDEV(NDEV)) chk_i (.*);

// File: tb/daisy_arbiter_tb.sv
`timescale 1ns/1ps
module daisy_arbiter_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] grant;
  logic         busy;
  logic [1:0]   midx;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  daisy_arbiter #(.NDEV(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
    .grant_o(grant), .bus_busy_o(busy), .master_o(midx)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_state(string tag, logic eb, logic [N-1:0] eg, logic [1:0] ei);
    n_cmp++;
    if (busy !== eb || grant !== eg || midx !== ei) begin
      n_bad++;
      $display("FAIL %s: busy=%0b grant=%b idx=%0d expected busy=%0b grant=%b idx=%0d",
               tag, busy, grant, midx, eb, eg, ei);
    end
  endtask

  function automatic logic [N-1:0] low_bit(logic [N-1:0] p);
    return p & (~p + 1'b1);
  endfunction

  function automatic logic [1:0] low_idx(logic [N-1:0] p);
    return 2'($clog2(int'(low_bit(p))));
  endfunction

  initial begin : watchdog
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] w;
    logic [1:0]   wi;
    @(negedge clk);
    tick();
    expect_state("R1 in reset", 1'b0, '0, 2'd0);
    rst_n = 1'b1;
    tick();
    expect_state("R1 after reset", 1'b0, '0, 2'd0);
    done = '1;
    tick();
    expect_state("R2/R7 idle, done while idle", 1'b0, '0, 2'd0);
    done = '0;

    for (int p = 1; p < (1 << N); p++) begin
      w  = low_bit(N'(p));
      wi = low_idx(N'(p));
      req = N'(p);
      tick();
      expect_state("R3/R4/R5 claim", 1'b1, w, wi);
      req = '0;
      tick();
      expect_state("R6 hold after request drop", 1'b1, w, wi);
      req = '1;
      done = ~w;
      tick();
      expect_state("R7/R10 foreign done, higher requests", 1'b1, w, wi);
      done = w;
      req = N'(p);
      tick();
      expect_state("R8 release", 1'b0, '0, 2'd0);
      done = '0;
      tick();
      expect_state("R9 recompete", 1'b1, w, wi);
      req = '0;
      done = w;
      tick();
      expect_state("R8 release to idle", 1'b0, '0, 2'd0);
      done = '0;
      tick();
      expect_state("R2 stay idle", 1'b0, '0, 2'd0);
    end

    req = 4'b1000;
    tick();
    expect_state("R4 lone low priority", 1'b1, 4'b1000, 2'd3);
    req = 4'b1001;
    done = 4'b1000;
    tick();
    expect_state("R8 release with waiting", 1'b0, '0, 2'd0);
    done = '0;
    tick();
    expect_state("R9/R10 waiting high priority wins", 1'b1, 4'b0001, 2'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule